// File: doc/BRIEF.md
# Parallel Port Fast Bus Cycle Generator

This block turns the eight data lines and a handful of control lines of a parallel port into a small external bus. It claims the host register offsets that sit above the three ordinary port registers. A host access to one of these offsets runs a complete handshake on the port by itself. Offset 3 runs an address cycle, using the address strobe. Offsets 4 to 7 run data cycles, using the data strobe. The write line is driven low whenever the host access is a write. The host does not toggle any control bit by hand.

The host side is a simple request/ready register bus. The host holds its request until the block raises `host_ready` for one clock, so each host access lasts exactly as long as the port cycle. Each port cycle has three phases. First comes a setup phase, with outgoing data already on the pins. Next the strobe is held low for a minimum time. After that the peripheral's wait line is sampled, and the peripheral may hold it low to stretch the cycle. A timeout ends a cycle that stays stuck in wait and records the event in a sticky flag. The peripheral's acknowledge line is brought back to the host as an interrupt request. Offsets 0 to 2 belong to ordinary register logic outside this block, and this block only completes them at once.

Top module: `ppbus_cycle_gen`

## Requirements
- R1: After reset `astb_n`, `dstb_n` and `write_n` are 1, `pd_oe`, `host_ready`, `timeout_flag` and `irq` are 0.
- R2: A request at offsets 0, 1 or 2 raises `host_ready` in the next clock with `host_rdata` = 0. It produces no strobe and never sets `pd_oe`, whether it is a read or a write.
- R3: An access at offset 3 runs an address cycle. `astb_n` is low during the strobe phase and `dstb_n` stays high. `write_n` is low during the strobe exactly when the access is a write, and on a write `pd_out` carries the written byte with `pd_oe` = 1.
- R4: An access at offsets 4 to 7 runs a data cycle. `dstb_n` is low during the strobe phase and `astb_n` stays high. `write_n` is low during the strobe exactly when the access is a write, and on a write `pd_out` carries the written byte with `pd_oe` = 1.
- R5: During a read cycle `write_n` stays high and `pd_oe` stays 0. `host_rdata` returns the `pd_in` value present in the clock in which `wait_n` is seen high. A completed write returns `host_rdata` = 0.
- R6: On a write, the data is driven with `pd_oe` = 1 for SETUP_CLKS (1) clock before the strobe falls. No strobe stays low for fewer than MIN_LOW (2) clocks.
- R7: `wait_n` is sampled from the last minimum strobe clock onward. Let the wait line be low for the first W strobe clocks, with W below TIMEOUT. Then the strobe stays low for max(2, W+1) clocks, and `host_ready` comes one clock after the strobe rises. From the request, an access to offsets 3 to 7 therefore takes strobe length + 2 clocks to reach `host_ready`.
- R8: If `wait_n` is still low in strobe clock TIMEOUT (255), the cycle ends after 255 strobe clocks. A read then returns FFh, and `timeout_flag` is set and stays set until reset.
- R9: `irq` is the inverse of `ack_n`, delayed by IRQ_SYNC (2) clocks.
- R10: `host_ready` is high for exactly one clock per access. `astb_n` and `dstb_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with host_ready |
| host_ready | output | 1 | One-clock completion pulse |
| pd_out | output | 8 | Data pins, outgoing value |
| pd_oe | output | 1 | Data pin driver enable |
| pd_in | input | 8 | Data pins, incoming value |
| astb_n | output | 1 | Address strobe, active low |
| dstb_n | output | 1 | Data strobe, active low |
| write_n | output | 1 | Write indication, active low |
| wait_n | input | 1 | Peripheral wait, low stretches the cycle |
| ack_n | input | 1 | Peripheral interrupt request, active low |
| irq | output | 1 | Interrupt request to host |
| timeout_flag | output | 1 | Sticky wait-timeout flag |

## Verification
The assertions assume that `wait_n` and `pd_in` are synchronous to `clk`. They also assume that the host keeps `host_req`, `host_we`, `host_addr` and `host_wdata` steady from the request until it sees `host_ready`, and then drops or changes them. The stimulus changes every input only on the falling clock edge. It drops the request in the same half-cycle in which `host_ready` is observed. A small peripheral model in the bench counts strobe-low clocks and releases `wait_n` after a chosen count. With that model the sweep covers every offset, both directions and several wait lengths, including the longest legal wait and a wait that never ends.

// File: rtl/ppbus_pkg.sv
package ppbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_STRB  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_ADDR = 2'd1,
        CK_DATA = 2'd2
    } cyc_kind_e;

endpackage

// File: rtl/ppbus_decode.sv
module ppbus_decode
    import ppbus_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int ADDR_OFS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output cyc_kind_e         kind
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(ADDR_OFS);

    always_comb begin
        if (addr == OFS)     kind = CK_ADDR;
        else if (addr > OFS) kind = CK_DATA;
        else                 kind = CK_NONE;
    end
endmodule

// File: rtl/ppbus_irq_sync.sv
module ppbus_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    output logic irq
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = ack_n;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], ack_n};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign irq = ~sync_q[STAGES-1];
endmodule

// File: rtl/ppbus_seq.sv
module ppbus_seq
    import ppbus_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SETUP_CLKS = 1,
    parameter int MIN_LOW    = 2,
    parameter int TIMEOUT    = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  cyc_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              wait_n,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              strb_addr,
    output logic              strb_data,
    output logic              write_act,
    output logic [DATA_W-1:0] dout,
    output logic              doe,
    output logic              tflag
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CLKS - 1);
    localparam logic [CNT_W-1:0] LOW_LAST   = CNT_W'(MIN_LOW - 1);
    localparam logic [CNT_W-1:0] TO_LAST    = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        cyc_kind_e         kind;
        logic              we;
        logic [DATA_W-1:0] wbyte;
        logic [DATA_W-1:0] rbyte;
        logic              tflag;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                d.cnt = '0;
                if (req) begin
                    d.kind  = kind;
                    d.we    = we;
                    d.wbyte = wdata;
                    if (kind == CK_NONE) begin
                        d.rbyte = '0;
                        d.state = ST_DONE;
                    end else begin
                        d.state = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (q.cnt == SETUP_LAST) begin
                    d.cnt   = '0;
                    d.state = ST_STRB;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_STRB: begin
                if (q.cnt >= LOW_LAST && wait_n) begin
                    d.rbyte = q.we ? '0 : pin_in;
                    d.state = ST_DONE;
                end else if (q.cnt == TO_LAST) begin
                    d.rbyte = q.we ? '0 : '1;
                    d.tflag = 1'b1;
                    d.state = ST_DONE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, kind: CK_NONE, we: 1'b0,
                   wbyte: '0, rbyte: '0, tflag: 1'b0};
        end else begin
            q <= d;
        end
    end

    logic strb_act;
    assign strb_act  = (q.state == ST_STRB);
    assign strb_addr = strb_act && (q.kind == CK_ADDR);
    assign strb_data = strb_act && (q.kind == CK_DATA);
    assign write_act = strb_act && q.we;
    assign doe       = q.we && (q.kind != CK_NONE) && (q.state != ST_IDLE);
    assign dout      = q.wbyte;
    assign ready     = (q.state == ST_DONE);
    assign rdata     = q.rbyte;
    assign tflag     = q.tflag;

    // R10: strobes exclusive, ready a single pulse
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb_addr && strb_data));
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R6: write data driven before strobe falls; strobe meets minimum width
    p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_act) && write_act |-> $past(doe) && $stable(dout));
    p_minlow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_act) |-> $past(q.cnt) >= LOW_LAST);
    // R7: low wait keeps the strobe active until the timeout limit
    p_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strb_act && !wait_n && (q.cnt < TO_LAST) |=> strb_act);
    // R5: drivers released during a read strobe
    p_rdhiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strb_act && !write_act |-> !doe);
    // R8: timeout flag is sticky and appears with completion
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tflag |=> tflag);
    p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tflag) |-> ready);
endmodule

// File: rtl/ppbus_cycle_gen.sv
module ppbus_cycle_gen
    import ppbus_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3,
    parameter int ADDR_OFS   = 3,
    parameter int SETUP_CLKS = 1,
    parameter int MIN_LOW    = 2,
    parameter int TIMEOUT    = 255,
    parameter int IRQ_SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [DATA_W-1:0] pd_in,
    output logic              astb_n,
    output logic              dstb_n,
    output logic              write_n,
    input  logic              wait_n,
    input  logic              ack_n,
    output logic              irq,
    output logic              timeout_flag
);
    cyc_kind_e kind;
    logic      strb_addr, strb_data, write_act;

    ppbus_decode #(.ADDR_W(ADDR_W), .ADDR_OFS(ADDR_OFS)) u_decode (
        .addr (host_addr),
        .kind (kind)
    );

    ppbus_seq #(
        .DATA_W(DATA_W), .SETUP_CLKS(SETUP_CLKS),
        .MIN_LOW(MIN_LOW), .TIMEOUT(TIMEOUT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_req),
        .we        (host_we),
        .kind      (kind),
        .wdata     (host_wdata),
        .pin_in    (pd_in),
        .wait_n    (wait_n),
        .ready     (host_ready),
        .rdata     (host_rdata),
        .strb_addr (strb_addr),
        .strb_data (strb_data),
        .write_act (write_act),
        .dout      (pd_out),
        .doe       (pd_oe),
        .tflag     (timeout_flag)
    );

    ppbus_irq_sync #(.STAGES(IRQ_SYNC)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ack_n (ack_n),
        .irq   (irq)
    );

    assign astb_n  = ~strb_addr;
    assign dstb_n  = ~strb_data;
    assign write_n = ~write_act;
endmodule

// File: tb/tb_ppbus_cycle_gen.sv
module tb_ppbus_cycle_gen;
    localparam int TIMEOUT = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ready;
    logic [7:0] pd_out;
    logic       pd_oe;
    logic [7:0] pd_in = '0;
    logic       astb_n, dstb_n, write_n;
    logic       wait_n = 1'b1;
    logic       ack_n = 1'b1;
    logic       irq, timeout_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ppbus_cycle_gen dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .astb_n(astb_n), .dstb_n(dstb_n), .write_n(write_n), .wait_n(wait_n),
        .ack_n(ack_n), .irq(irq), .timeout_flag(timeout_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one host access with a peripheral that holds wait low for wl strobe clocks
    task automatic access(input logic [2:0] a, input bit w, input logic [7:0] wd,
                          input logic [7:0] pin, input int wl);
        int  cycles = 0, nlow = 0, both = 0, badk = 0, badwr = 0, badd = 0, badoe = 0;
        bit  any_oe = 0, setup_ok = 1, prev_oe = 0, timed;
        logic [7:0] prev_d = '0, rd = '0;
        int  exp_low, exp_cyc, kind;
        kind = (a < 3) ? 0 : (a == 3) ? 1 : 2;
        host_req = 1'b1; host_we = w; host_addr = a; host_wdata = wd;
        pd_in = pin; wait_n = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            cycles++;
            if (pd_oe) any_oe = 1;
            if (!astb_n && !dstb_n) both++;
            if (!astb_n || !dstb_n) begin
                nlow++;
                if ((kind == 1 && !dstb_n) || (kind == 2 && !astb_n)) badk++;
                if (write_n != !w) badwr++;
                if (w && (!pd_oe || pd_out != wd)) badd++;
                if (!w && pd_oe) badoe++;
                if (nlow == 1 && w && !(prev_oe && prev_d == wd)) setup_ok = 0;
                wait_n = (nlow > wl);
            end else begin
                wait_n = 1'b1;
            end
            prev_oe = pd_oe; prev_d = pd_out;
            if (host_ready) begin
                rd = host_rdata;
                host_req = 1'b0;
                break;
            end
        end
        @(negedge clk);
        chk(!host_ready, "R10 ready pulse", host_ready, 0);
        chk(both == 0, "R10 strobe exclusive", both, 0);
        if (kind == 0) begin
            chk(cycles == 1, "R2 latency", cycles, 1);
            chk(nlow == 0 && !any_oe, "R2 no pin activity", nlow, 0);
            chk(rd == 8'h00, "R2 rdata", rd, 0);
        end else begin
            timed   = (wl > TIMEOUT - 1);
            exp_low = timed ? TIMEOUT : ((wl + 1 > 2) ? wl + 1 : 2);
            exp_cyc = exp_low + 2;
            chk(nlow == exp_low, "R7 strobe length", nlow, exp_low);
            chk(cycles == exp_cyc, "R7 access latency", cycles, exp_cyc);
            chk(badk == 0, (kind == 1) ? "R3 address strobe" : "R4 data strobe", badk, 0);
            chk(badwr == 0, "R5 write line", badwr, 0);
            chk(badd == 0, (kind == 1) ? "R3 write data" : "R4 write data", badd, 0);
            chk(badoe == 0, "R5 read drivers off", badoe, 0);
            chk(setup_ok, "R6 setup before strobe", setup_ok, 1);
            chk(rd == (w ? 8'h00 : (timed ? 8'hFF : pin)),
                timed ? "R8 timeout rdata" : "R5 rdata", rd,
                w ? 0 : (timed ? 255 : pin));
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(astb_n && dstb_n && write_n, "R1 strobes idle", {astb_n, dstb_n, write_n}, 7);
        chk(!pd_oe && !host_ready, "R1 oe/ready", {pd_oe, host_ready}, 0);
        chk(!timeout_flag && !irq, "R1 flags", {timeout_flag, irq}, 0);

        // sweep offsets, direction, wait lengths
        foreach (wls[j]) ;
        for (int a = 0; a < 8; a++)
            for (int w = 0; w < 2; w++)
                for (int k = 0; k < 4; k++) begin
                    int wl = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 6;
                    logic [7:0] wd = 8'(a * 37 + wl * 11 + w);
                    access(3'(a), w[0], wd, ~wd ^ 8'h5A, wl);
                end
        // longest legal wait: no timeout
        access(3'd5, 1'b0, 8'h00, 8'hC3, TIMEOUT - 1);
        chk(!timeout_flag, "R8 no timeout at limit", timeout_flag, 0);
        // stuck wait on read
        access(3'd6, 1'b0, 8'h00, 8'h12, 1000);
        chk(timeout_flag, "R8 flag set", timeout_flag, 1);
        // flag sticky across normal accesses
        access(3'd4, 1'b0, 8'h00, 8'h9E, 2);
        access(3'd3, 1'b1, 8'hA7, 8'h00, 0);
        chk(timeout_flag, "R8 flag sticky", timeout_flag, 1);
        access(3'd7, 1'b1, 8'h3C, 8'h00, 1000);
        chk(timeout_flag, "R8 flag after write timeout", timeout_flag, 1);

        // R9 interrupt path
        ack_n = 1'b0;
        @(negedge clk);
        chk(!irq, "R9 irq after one clock", irq, 0);
        @(negedge clk);
        chk(irq, "R9 irq after two clocks", irq, 1);
        ack_n = 1'b1;
        @(negedge clk);
        chk(irq, "R9 irq held one clock", irq, 1);
        @(negedge clk);
        chk(!irq, "R9 irq released", irq, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int wls[1];
endmodule